// File: doc/BRIEF.md
# MDIO Indirect Register Bridge

This block is a management slave that sits on a Clause 22 MDIO bus. It gives an external host read and write access to a 16-bit internal register space, even though MDIO itself only addresses 32 registers per PHY address. The host first writes the internal target address into MDIO register 0x1F. It then reads or writes MDIO register 0, and the bridge turns that access into a 16-bit transfer on an internal request/acknowledge bus at the stored target address. Each access is one pair of frames: the address frame, then the data frame.

The MDC clock and the MDIO input are oversampled in the system clock domain. Frames that carry another PHY address, an unknown opcode or too short a preamble are ignored, and the bridge never drives the line for them. Only two internal address windows are accepted. A read outside them returns zero, and a write outside them never reaches the internal bus. A small test register file sits behind the bus so that the data path can be exercised from the MDIO pins alone.

Top module: `mdio_indirect_bridge`

## Requirements
- R1: After reset the MDIO output enable is low, and the stored target address is 0x0000.
- R2: A frame is accepted only when all of the following hold. It has at least PRE_MIN consecutive ones, then the start bits 0,1, then a 2-bit opcode (1,0 = read; 0,1 = write), a 5-bit PHY address MSB first and a 5-bit register number MSB first. Then come two turnaround bits and 16 data bits MSB first, and bits are sampled on rising MDC edges.
- R3: A frame whose PHY address differs from `phy_addr_i` has no effect on any state, and the output enable stays low for its whole length.
- R4: A write to MDIO register 0x1F stores its data as the target address. A read of register 0x1F returns the stored target address.
- R5: A write to MDIO register 0 stores its data in the internal register at the target address, if that address is valid.
- R6: A read of MDIO register 0 returns the contents of the internal register at the target address, if that address is valid.
- R7: The valid addresses are 0xE000 to 0xED46 and 0xF400 to 0xF822, bounds included. For any other address, a read of register 0 returns 0x0000 and a write to register 0 changes no internal register.
- R8: On an accepted read, the output enable goes high after the MDC rise that samples the first turnaround bit, and the line is 0 at the second turnaround bit. Each data bit changes only after an MDC rise. The enable drops after the rise that samples the last data bit.
- R9: A frame that is preceded by fewer than PRE_MIN ones is ignored.
- R10: The test register file holds 2^IDX_W words for each window. A word is selected by the window and by the low IDX_W address bits, so addresses that differ only above those bits share a word inside one window (default IDX_W = 3).
- R11: Writes to MDIO registers other than 0 and 0x1F are ignored, and reads of them return 0x0000.
- R12: A frame with opcode 0,0 or 1,1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples MDC |
| rst_n | input | 1 | Active-low synchronous reset |
| phy_addr_i | input | 5 | Strapped PHY address this slave answers to |
| mdc_i | input | 1 | Management clock from the host |
| mdio_i | input | 1 | Management data line as seen at the pin |
| mdio_o | output | 1 | Data the slave drives during reads |
| mdio_oe_o | output | 1 | Output enable for the data line |

## Verification
The write of a register-0 frame reaches the internal bus on the same MDC edge at which the frame decoder rearms its preamble hunt. The bench therefore sends the next frame's preamble with no idle gap: a data write is followed at once by a read of the same word. It judges the overlap by the returned value and by that read frame being accepted at all. A second overlap is the read launch toward the internal bus while the header is still being decoded. It is judged by the turnaround timing and by the data reaching the line before the first data bit.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 16;
    localparam int NUM_WIN = 2;

    // Inclusive bounds of the accepted internal windows (index 0 first).
    localparam logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_LO = {16'hF400, 16'hE000};
    localparam logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_HI = {16'hF822, 16'hED46};

    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    localparam logic [4:0] REG_DATA = 5'h00;
    localparam logic [4:0] REG_ADDR = 5'h1F;

    typedef enum logic [2:0] {
        ST_PRE,
        ST_START,
        ST_HDR,
        ST_TA,
        ST_DATA
    } frame_state_e;

endpackage

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_i,
    input  logic mdio_i,
    output logic rise_o,
    output logic bit_o
);
    typedef struct packed {
        logic [STAGES-1:0] mdc;
        logic [STAGES-1:0] dat;
        logic              mdc_last;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.mdc      = {q.mdc[STAGES-2:0], mdc_i};
        d.dat      = {q.dat[STAGES-2:0], mdio_i};
        d.mdc_last = q.mdc[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.mdc      <= '0;
            q.dat      <= '1;
            q.mdc_last <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rise_o = q.mdc[STAGES-1] & ~q.mdc_last;
    assign bit_o  = q.dat[STAGES-1];

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_bridge_pkg::*;
#(
    parameter int PRE_MIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        phy_addr_i,
    input  logic              rise_i,
    input  logic              bit_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              launch_o,
    output logic              commit_o,
    output logic [4:0]        reg_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              mdio_o,
    output logic              mdio_oe_o
);
    localparam int CW = $clog2(PRE_MIN + 1);
    localparam logic [CW-1:0] PRE_LIM = CW'(PRE_MIN);

    typedef struct packed {
        frame_state_e      st;
        logic [CW-1:0]     ones;
        logic [3:0]        cnt;
        logic [11:0]       hdr;
        logic [DATA_W-1:0] sh;
        logic              rd;
        logic              oe;
        logic              o;
        logic              launch;
        logic              commit;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d        = q;
        d.launch = 1'b0;
        d.commit = 1'b0;
        if (rise_i) begin
            unique case (q.st)
                ST_PRE: begin
                    if (bit_i) begin
                        if (q.ones != PRE_LIM) d.ones = q.ones + 1'b1;
                    end else begin
                        d.ones = '0;
                        if (q.ones == PRE_LIM) d.st = ST_START;
                    end
                end
                ST_START: begin
                    d.cnt = 4'd0;
                    d.st  = bit_i ? ST_HDR : ST_PRE;
                end
                ST_HDR: begin
                    d.hdr = {q.hdr[10:0], bit_i};
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == 4'd11) begin
                        d.cnt = 4'd0;
                        if ((d.hdr[9:5] == phy_addr_i) &&
                            ((d.hdr[11:10] == OP_RD) || (d.hdr[11:10] == OP_WR))) begin
                            d.st     = ST_TA;
                            d.rd     = (d.hdr[11:10] == OP_RD);
                            d.launch = (d.hdr[11:10] == OP_RD);
                        end else begin
                            d.st = ST_PRE;
                        end
                    end
                end
                ST_TA: begin
                    if (q.cnt == 4'd0) begin
                        d.cnt = 4'd1;
                        if (q.rd) begin
                            d.oe = 1'b1;
                            d.o  = 1'b0;
                        end
                    end else begin
                        d.cnt = 4'd0;
                        d.st  = ST_DATA;
                        if (q.rd) begin
                            d.o  = rd_data_i[DATA_W-1];
                            d.sh = {rd_data_i[DATA_W-2:0], 1'b0};
                        end
                    end
                end
                ST_DATA: begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.rd) begin
                        if (q.cnt != 4'd15) begin
                            d.o  = q.sh[DATA_W-1];
                            d.sh = {q.sh[DATA_W-2:0], 1'b0};
                        end else begin
                            d.oe = 1'b0;
                            d.o  = 1'b1;
                        end
                    end else begin
                        d.sh = {q.sh[DATA_W-2:0], bit_i};
                    end
                    if (q.cnt == 4'd15) begin
                        d.st     = ST_PRE;
                        d.ones   = '0;
                        d.rd     = 1'b0;
                        d.commit = ~q.rd;
                    end
                end
                default: d.st = ST_PRE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st     <= ST_PRE;
            q.ones   <= '0;
            q.cnt    <= '0;
            q.hdr    <= '0;
            q.sh     <= '0;
            q.rd     <= 1'b0;
            q.oe     <= 1'b0;
            q.o      <= 1'b1;
            q.launch <= 1'b0;
            q.commit <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign launch_o  = q.launch;
    assign commit_o  = q.commit;
    assign reg_o     = q.hdr[4:0];
    assign wdata_o   = q.sh;
    assign mdio_o    = q.o;
    assign mdio_oe_o = q.oe;

    // R8: the line only moves in the cycle after a detected MDC rise
    p_out_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_i |=> ($stable(mdio_o) && $stable(mdio_oe_o)));

    // R2: a request toward the bus follows a detected MDC rise
    p_pulse_after_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_o || commit_o) |-> $past(rise_i));

endmodule

// File: rtl/window_check.sv
module window_check
    import mdio_bridge_pkg::*;
#(
    localparam int SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [SEL_W-1:0]  sel_o
);
    logic [NUM_WIN-1:0] hits;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        assign hits[g] = (addr_i >= WIN_LO[g]) && (addr_i <= WIN_HI[g]);
    end

    always_comb begin
        sel_o = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (hits[i]) sel_o = SEL_W'(i);
        end
    end

    assign hit_o = |hits;

endmodule

// File: rtl/reg_window_master.sv
module reg_window_master
    import mdio_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic              commit_i,
    input  logic [4:0]        reg_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic [DATA_W-1:0] bus_rdata_i
);
    typedef struct packed {
        logic [ADDR_W-1:0] tgt;
        logic [DATA_W-1:0] rdata;
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } mst_t;

    mst_t q, d;
    logic in_win;
    logic win_sel;

    window_check u_win (
        .addr_i (q.tgt),
        .hit_o  (in_win),
        .sel_o  (win_sel)
    );

    always_comb begin
        d = q;
        if (q.req && bus_ack_i) begin
            d.req = 1'b0;
            if (!q.we) d.rdata = bus_rdata_i;
        end
        if (launch_i) begin
            d.rdata = '0;
            if (reg_i == REG_ADDR) begin
                d.rdata = q.tgt;
            end else if ((reg_i == REG_DATA) && in_win) begin
                d.req  = 1'b1;
                d.we   = 1'b0;
                d.addr = q.tgt;
            end
        end
        if (commit_i) begin
            if (reg_i == REG_ADDR) begin
                d.tgt = wdata_i;
            end else if ((reg_i == REG_DATA) && in_win) begin
                d.req   = 1'b1;
                d.we    = 1'b1;
                d.addr  = q.tgt;
                d.wdata = wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata_o     = q.rdata;
    assign bus_req_o   = q.req;
    assign bus_we_o    = q.we;
    assign bus_addr_o  = q.addr;
    assign bus_wdata_o = q.wdata;

    // R5: a pending request holds its payload until acknowledged
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=>
            (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o)));

    // R7: an out-of-window data write never raises a request
    p_drop_outside_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && (reg_i == REG_DATA) && !in_win && !bus_req_o) |=> !bus_req_o);

    // R10: the window used for the request matches the latched target
    p_sel_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_i && in_win) |-> (win_sel == (q.tgt >= WIN_LO[1])));

endmodule

// File: rtl/test_regfile.sv
module test_regfile
    import mdio_bridge_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int SEL_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
    localparam int WORDS   = NUM_WIN << IDX_W;
    localparam int INDEX_W = SEL_W + IDX_W;

    logic [DATA_W-1:0] mem_q [WORDS];
    logic [DATA_W-1:0] mem_d [WORDS];
    logic              ack_q, ack_d;
    logic [DATA_W-1:0] rd_q, rd_d;
    logic              hit;
    logic [SEL_W-1:0]  sel;
    logic [INDEX_W-1:0] idx;

    window_check u_win (
        .addr_i (addr_i),
        .hit_o  (hit),
        .sel_o  (sel)
    );

    assign idx = {sel, addr_i[IDX_W-1:0]};

    always_comb begin
        mem_d = mem_q;
        ack_d = 1'b0;
        rd_d  = rd_q;
        if (req_i && !ack_q) begin
            ack_d = 1'b1;
            rd_d  = hit ? mem_q[idx] : '0;
            if (we_i && hit) mem_d[idx] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
            ack_q <= 1'b0;
            rd_q  <= '0;
        end else begin
            mem_q <= mem_d;
            ack_q <= ack_d;
            rd_q  <= rd_d;
        end
    end

    assign ack_o   = ack_q;
    assign rdata_o = rd_q;

    // R7: only in-window addresses are ever requested
    p_req_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |-> hit);

    // R10: every acknowledge answers a request of the previous cycle
    p_ack_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(req_i));

endmodule

// File: rtl/mdio_indirect_bridge.sv
module mdio_indirect_bridge
    import mdio_bridge_pkg::*;
#(
    parameter int PRE_MIN     = 32,
    parameter int SYNC_STAGES = 2,
    parameter int IDX_W       = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] phy_addr_i,
    input  logic       mdc_i,
    input  logic       mdio_i,
    output logic       mdio_o,
    output logic       mdio_oe_o
);
    logic              rise;
    logic              sbit;
    logic              launch;
    logic              commit;
    logic [4:0]        regad;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;
    logic              bus_req;
    logic              bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic              bus_ack;
    logic [DATA_W-1:0] bus_rdata;

    mdio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .mdc_i  (mdc_i),
        .mdio_i (mdio_i),
        .rise_o (rise),
        .bit_o  (sbit)
    );

    mdio_frame_engine #(.PRE_MIN(PRE_MIN)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .phy_addr_i (phy_addr_i),
        .rise_i     (rise),
        .bit_i      (sbit),
        .rd_data_i  (rdata),
        .launch_o   (launch),
        .commit_o   (commit),
        .reg_o      (regad),
        .wdata_o    (wdata),
        .mdio_o     (mdio_o),
        .mdio_oe_o  (mdio_oe_o)
    );

    reg_window_master u_master (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (launch),
        .commit_i    (commit),
        .reg_i       (regad),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .bus_req_o   (bus_req),
        .bus_we_o    (bus_we),
        .bus_addr_o  (bus_addr),
        .bus_wdata_o (bus_wdata),
        .bus_ack_i   (bus_ack),
        .bus_rdata_i (bus_rdata)
    );

    test_regfile #(.IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (bus_req),
        .we_i    (bus_we),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .ack_o   (bus_ack),
        .rdata_o (bus_rdata)
    );

    // R6: an internal read completes before the engine drives the first data bit
    p_read_done_before_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe_o) |-> !bus_req);

endmodule

// File: tb/test_mdio_indirect_bridge.sv
module test_mdio_indirect_bridge;

    localparam int HALF = 8;
    localparam logic [4:0] MY_PHY = 5'h05;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] phy_addr = MY_PHY;
    logic       mdc = 1'b0;
    logic       host_val = 1'b1;
    logic       mdio_o;
    logic       mdio_oe;
    logic       line;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    assign line = mdio_oe ? mdio_o : host_val;

    mdio_indirect_bridge i_mdio_indirect_bridge (
        .clk        (clk),
        .rst_n      (rst_n),
        .phy_addr_i (phy_addr),
        .mdc_i      (mdc),
        .mdio_i     (line),
        .mdio_o     (mdio_o),
        .mdio_oe_o  (mdio_oe)
    );

    // results of the latest frame
    logic [15:0] last_rd;
    logic        last_drove;
    logic        last_ta1_oe;
    logic        last_ta2_oe;
    logic        last_ta2_line;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic bit_cycle(input logic b, output logic smp, output logic oe_s);
        host_val = b;
        repeat (HALF) @(negedge clk);
        smp  = line;
        oe_s = mdio_oe;
        mdc  = 1'b1;
        repeat (HALF) @(negedge clk);
        mdc  = 1'b0;
    endtask

    task automatic frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] regad,
                         input logic [15:0] data, input int pre);
        logic s, o;
        logic is_rd;
        is_rd = (op == 2'b10);
        last_drove = 1'b0;
        last_rd = '0;
        for (int i = 0; i < pre; i++) begin bit_cycle(1'b1, s, o); last_drove |= o; end
        bit_cycle(1'b0, s, o); last_drove |= o;
        bit_cycle(1'b1, s, o); last_drove |= o;
        for (int i = 1; i >= 0; i--) begin bit_cycle(op[i], s, o); last_drove |= o; end
        for (int i = 4; i >= 0; i--) begin bit_cycle(phy[i], s, o); last_drove |= o; end
        for (int i = 4; i >= 0; i--) begin bit_cycle(regad[i], s, o); last_drove |= o; end
        bit_cycle(1'b1, s, o); last_ta1_oe = o; last_drove |= o;
        bit_cycle(is_rd ? 1'b1 : 1'b0, s, o); last_ta2_oe = o; last_ta2_line = s; last_drove |= o;
        for (int i = 15; i >= 0; i--) begin
            bit_cycle(is_rd ? 1'b1 : data[i], s, o);
            last_rd[i] = s;
            last_drove |= o;
        end
        host_val = 1'b1;
    endtask

    task automatic wr(input logic [4:0] regad, input logic [15:0] data);
        frame(2'b01, phy_addr, regad, data, 32);
    endtask

    task automatic rd(input logic [4:0] regad, output logic [15:0] val);
        frame(2'b10, phy_addr, regad, 16'h0000, 32);
        val = last_rd;
    endtask

    task automatic access_wr(input logic [15:0] addr, input logic [15:0] data);
        wr(5'h1F, addr);
        wr(5'h00, data);
    endtask

    task automatic access_rd(input logic [15:0] addr, output logic [15:0] val);
        wr(5'h1F, addr);
        rd(5'h00, val);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        chk("R1 oe after reset", {15'd0, mdio_oe}, 16'h0000);
        rd(5'h1F, v);
        chk("R1 target address after reset", v, 16'h0000);
    endtask

    task automatic t_addr_latch;
        logic [15:0] v;
        wr(5'h1F, 16'hE003);
        rd(5'h1F, v);
        chk("R4 target address readback", v, 16'hE003);
    endtask

    task automatic t_data_rw;
        logic [15:0] v;
        access_wr(16'hE003, 16'hA5C3);
        rd(5'h00, v);
        chk("R5 R6 data write then back-to-back read", v, 16'hA5C3);
        access_wr(16'hE004, 16'h5A3C);
        access_rd(16'hE004, v);
        chk("R6 second word", v, 16'h5A3C);
        access_rd(16'hE003, v);
        chk("R5 first word kept", v, 16'hA5C3);
    endtask

    task automatic t_turnaround;
        logic [15:0] v;
        access_rd(16'hE003, v);
        chk("R8 oe low at first turnaround bit", {15'd0, last_ta1_oe}, 16'h0000);
        chk("R8 oe high at second turnaround bit", {15'd0, last_ta2_oe}, 16'h0001);
        chk("R8 line zero at second turnaround bit", {15'd0, last_ta2_line}, 16'h0000);
        repeat (2) @(negedge clk);
        chk("R8 oe released after last data bit", {15'd0, mdio_oe}, 16'h0000);
    endtask

    task automatic t_window_edges;
        logic [15:0] v;
        access_wr(16'hED46, 16'h1111);
        access_rd(16'hED46, v);
        chk("R7 upper bound of first window", v, 16'h1111);
        access_wr(16'hE007, 16'h7777);
        access_wr(16'hED47, 16'h2222);
        access_rd(16'hED47, v);
        chk("R7 read above first window", v, 16'h0000);
        access_rd(16'hE007, v);
        chk("R7 dropped write left word intact", v, 16'h7777);
        access_wr(16'hF400, 16'hBEEF);
        access_rd(16'hF400, v);
        chk("R7 lower bound of second window", v, 16'hBEEF);
        access_wr(16'hF822, 16'hC0DE);
        access_rd(16'hF822, v);
        chk("R7 upper bound of second window", v, 16'hC0DE);
        access_rd(16'hF823, v);
        chk("R7 read above second window", v, 16'h0000);
        access_rd(16'hDFFF, v);
        chk("R7 read below first window", v, 16'h0000);
        access_rd(16'hF3FF, v);
        chk("R7 read between windows", v, 16'h0000);
    endtask

    task automatic t_alias;
        logic [15:0] v;
        access_wr(16'hE001, 16'h0101);
        access_rd(16'hE009, v);
        chk("R10 alias within first window", v, 16'h0101);
        access_wr(16'hF401, 16'h4401);
        access_rd(16'hE001, v);
        chk("R10 windows hold separate words", v, 16'h0101);
        access_rd(16'hF409, v);
        chk("R10 alias within second window", v, 16'h4401);
    endtask

    task automatic t_phy_mismatch;
        logic [15:0] v;
        wr(5'h1F, 16'hE002);
        frame(2'b01, phy_addr ^ 5'h01, 5'h1F, 16'h1234, 32);
        chk("R3 no drive on foreign write", {15'd0, last_drove}, 16'h0000);
        frame(2'b10, phy_addr ^ 5'h10, 5'h1F, 16'h0000, 32);
        chk("R3 no drive on foreign read", {15'd0, last_drove}, 16'h0000);
        rd(5'h1F, v);
        chk("R3 target address untouched", v, 16'hE002);
    endtask

    task automatic t_short_pre;
        logic [15:0] v;
        frame(2'b01, phy_addr, 5'h1F, 16'h1234, 8);
        rd(5'h1F, v);
        chk("R9 short preamble ignored", v, 16'hE002);
    endtask

    task automatic t_bad_op;
        logic [15:0] v;
        frame(2'b11, phy_addr, 5'h1F, 16'h1234, 32);
        chk("R12 no drive on opcode 11", {15'd0, last_drove}, 16'h0000);
        frame(2'b00, phy_addr, 5'h1F, 16'h4321, 32);
        chk("R12 no drive on opcode 00", {15'd0, last_drove}, 16'h0000);
        rd(5'h1F, v);
        chk("R12 target address untouched", v, 16'hE002);
        chk("R2 accepted read drives line", {15'd0, last_drove}, 16'h0001);
    endtask

    task automatic t_other_reg;
        logic [15:0] v;
        wr(5'h05, 16'h9999);
        rd(5'h05, v);
        chk("R11 other register reads zero", v, 16'h0000);
        rd(5'h1F, v);
        chk("R11 other register write ignored", v, 16'hE002);
    endtask

    task automatic t_strap_change;
        logic [15:0] v;
        phy_addr = 5'h1F;
        repeat (4) @(negedge clk);
        access_wr(16'hF402, 16'h3C3C);
        access_rd(16'hF402, v);
        chk("R3 R2 access at new strap", v, 16'h3C3C);
        frame(2'b10, MY_PHY, 5'h1F, 16'h0000, 32);
        chk("R3 old address no longer answered", {15'd0, last_drove}, 16'h0000);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_addr_latch();
        t_data_rw();
        t_turnaround();
        t_window_edges();
        t_alias();
        t_phy_mismatch();
        t_short_pre();
        t_bad_op();
        t_other_reg();
        t_strap_change();
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule